// File: doc/BRIEF.md
# Transfer Abort Cause Capture Register

This block gathers the reasons a two-wire bus controller gave up on a transmit operation and presents them as one 32-bit status word. The master and slave state machines report each abort reason as a single-cycle pulse. Each pulse sets a sticky flag that stays set until software reads one of two clearing strobes. One strobe is a dedicated abort-clear read and the other is a global interrupt-clear read. While any flag is set, a summary abort interrupt stays raised.

One flag behaves differently. It records an attempt to send a START byte while restart is disabled. If software clears this flag while that configuration fault is still present, the flag drops to zero for exactly one cycle and then sets again. The upper nine bits of the word count the transmit commands that were flushed because of an abort. These bits saturate at their maximum value. They clear only when the controller is disabled, and the read strobes leave them alone.

The block has no data streams, so every pin is a plain control or status level or pulse, and no valid/ready handshake or back-pressure applies. The status word is a registered output and is valid on every cycle.

Top module: `abort_cause_reg`

## Requirements
- R1: After reset, `status_o` is all zero and `abort_irq_o` is 0.
- R2: A pulse on `abort_evt_i[n]` sets status bit n on the next clock edge. The bit stays set until a clear strobe is seen. Bit index n and event index n are the same.
- R3: A pulse on `abort_evt_i[14]` (slave lost the bus) sets status bit 14 and status bit 12 (arbitration lost) on the same edge.
- R4: A pulse on `user_abort_i` sets status bit 16.
- R5: A cycle with `clr_abort_rd_i` or `clr_all_rd_i` high clears status bits 16:0 on the next edge, or both strobes together do the same. The only exception is the case in R6.
- R6: The START-byte fault is present when `restart_en_i`=0, `special_en_i`=1 and `start_byte_sel_i`=1. If status bit 9 is set and is cleared while this fault is present, bit 9 reads 0 for exactly one cycle and then reads 1 again. If bit 9 was already 0 when the clear arrives, it stays 0.
- R7: If `restart_en_i`=1, or `special_en_i`=0, or `start_byte_sel_i`=0, then a clear strobe clears bit 9 like any other flag.
- R8: If an abort event and a clear strobe arrive in the same cycle, the flag for that event is set after the edge.
- R9: `abort_irq_o` is 1 exactly when any of status bits 16:0 is 1.
- R10: Each cycle with `flush_pulse_i`=1 and `ctrl_en_i`=1 adds one to the flush count in status bits 31:23. The read strobes do not change the count.
- R11: The flush count saturates at 511 and does not wrap.
- R12: A cycle with `ctrl_en_i`=0 sets the flush count to 0 on the next edge. This holds even when a flush pulse arrives in the same cycle.
- R13: Status bits 22:17 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort_evt_i | input | 16 | Single-cycle abort cause pulses, one per status bit 15:0 |
| user_abort_i | input | 1 | Single-cycle pulse for a master abort requested by the user |
| flush_pulse_i | input | 1 | One pulse per flushed transmit command |
| restart_en_i | input | 1 | Restart enable configuration level |
| special_en_i | input | 1 | Special-command enable configuration level |
| start_byte_sel_i | input | 1 | START-byte select configuration level |
| ctrl_en_i | input | 1 | Controller enable level; 0 clears the flush count |
| clr_abort_rd_i | input | 1 | Abort-clear read strobe |
| clr_all_rd_i | input | 1 | Global interrupt-clear read strobe |
| status_o | output | 32 | Count [31:23], zeros [22:17], user abort [16], causes [15:0] |
| abort_irq_o | output | 1 | Summary abort interrupt |

## Verification
The assertions assume that reset is applied first and that every input is a clean synchronous level sampled at the clock edge. They also assume the configuration levels are steady across the cycles being checked. The bench changes every input only on the falling edge and leaves the inputs steady through each rising edge. It holds the configuration steady around each clear of bit 9, so the one-cycle drop is seen under a fixed fault condition. Event pulses and strobes last exactly one cycle in the table-driven part. Flush pulses are held for long runs only to reach saturation.

// File: rtl/abort_cause_pkg.sv
package abort_cause_pkg;
  parameter int STATUS_W    = 32;
  parameter int CAUSE_W     = 16;
  parameter int CNT_W       = 9;
  parameter int SBYTE_BIT   = 9;
  parameter int ARB_BIT     = 12;
  parameter int SLVLOST_BIT = 14;
  localparam int FLAG_W = CAUSE_W + 1;
  localparam int RSV_W  = STATUS_W - FLAG_W - CNT_W;

  typedef struct packed {
    logic restart_en;
    logic special_en;
    logic sbyte_sel;
  } abt_cfg_t;
endpackage

// File: rtl/abt_fault_decode.sv
module abt_fault_decode
  import abort_cause_pkg::*;
(
  input  abt_cfg_t cfg_i,
  output logic     sbyte_fault_o
);
  // The fault persists while restart is off and both start-byte selects are on.
  always_comb begin
    sbyte_fault_o = ~cfg_i.restart_en & cfg_i.special_en & cfg_i.sbyte_sel;
  end
endmodule

// File: rtl/abt_flag_bank.sv
module abt_flag_bank #(
  parameter int N           = 16,
  parameter int SBYTE_BIT   = 9,
  parameter int ARB_BIT     = 12,
  parameter int SLVLOST_BIT = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         user_abort_i,
  input  logic         clr_i,
  input  logic         sbyte_fault_i,
  output logic [N:0]   flags_o
);
  logic [N:0] set_v;
  logic [N:0] flag_q;
  logic       rearm_q;

  always_comb begin
    set_v            = {user_abort_i, evt_i};
    set_v[ARB_BIT]   = evt_i[ARB_BIT] | evt_i[SLVLOST_BIT];
    set_v[SBYTE_BIT] = evt_i[SBYTE_BIT] | rearm_q;
  end

  // One sticky cell per cause; a new event beats a same-cycle clear.
  for (genvar g = 0; g <= N; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q[g] <= 1'b0;
      else if (set_v[g]) flag_q[g] <= 1'b1;
      else if (clr_i)    flag_q[g] <= 1'b0;
    end
  end

  // Remember a clear that hit the start-byte flag while its fault persists.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rearm_q <= 1'b0;
    else        rearm_q <= clr_i & flag_q[SBYTE_BIT] & sbyte_fault_i & ~evt_i[SBYTE_BIT];
  end

  assign flags_o = flag_q;

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  // R3
  pair_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i[SLVLOST_BIT] |=> (flag_q[SLVLOST_BIT] && flag_q[ARB_BIT]));
  // R5
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt_i == '0 && !user_abort_i && !rearm_q && !sbyte_fault_i) |=> (flag_q == '0));
  // R6
  sbyte_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && flag_q[SBYTE_BIT] && sbyte_fault_i && !evt_i[SBYTE_BIT]) |=> !flag_q[SBYTE_BIT]);
  // R6
  sbyte_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_q |=> flag_q[SBYTE_BIT]);
  // R8
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt_i != '0) |=> ((flag_q[N-1:0] & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/abt_flush_counter.sv
module abt_flush_counter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         pulse_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (!en_i)                 cnt_q <= '0;
    else if (pulse_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R10
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && pulse_i && cnt_q != MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R11
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cnt_q == MAX) |=> (cnt_q == MAX));
  // R12
  cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/abort_cause_reg.sv
module abort_cause_reg
  import abort_cause_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CAUSE_W-1:0]  abort_evt_i,
  input  logic                user_abort_i,
  input  logic                flush_pulse_i,
  input  logic                restart_en_i,
  input  logic                special_en_i,
  input  logic                start_byte_sel_i,
  input  logic                ctrl_en_i,
  input  logic                clr_abort_rd_i,
  input  logic                clr_all_rd_i,
  output logic [STATUS_W-1:0] status_o,
  output logic                abort_irq_o
);
  abt_cfg_t           cfg;
  logic               sbyte_fault;
  logic               clr_any;
  logic [FLAG_W-1:0]  flags;
  logic [CNT_W-1:0]   flush_cnt;

  assign cfg     = '{restart_en: restart_en_i, special_en: special_en_i, sbyte_sel: start_byte_sel_i};
  assign clr_any = clr_abort_rd_i | clr_all_rd_i;

  abt_fault_decode u_fault (.cfg_i(cfg), .sbyte_fault_o(sbyte_fault));

  abt_flag_bank #(
    .N(CAUSE_W), .SBYTE_BIT(SBYTE_BIT), .ARB_BIT(ARB_BIT), .SLVLOST_BIT(SLVLOST_BIT)
  ) u_flags (
    .clk(clk), .rst_n(rst_n), .evt_i(abort_evt_i), .user_abort_i(user_abort_i),
    .clr_i(clr_any), .sbyte_fault_i(sbyte_fault), .flags_o(flags)
  );

  abt_flush_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en_i(ctrl_en_i), .pulse_i(flush_pulse_i), .cnt_o(flush_cnt)
  );

  assign status_o    = {flush_cnt, {RSV_W{1'b0}}, flags};
  assign abort_irq_o = |flags;

  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_irq_o == (status_o[FLAG_W-1:0] != '0));
  // R4
  user_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    user_abort_i |=> status_o[CAUSE_W]);
  // R12
  cnt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en_i && !flush_pulse_i) |=> $stable(status_o[STATUS_W-1 -: CNT_W]));
endmodule

// File: tb/abort_cause_reg_test.sv
module abort_cause_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic        usr = 1'b0, flush = 1'b0;
  logic        rst_en = 1'b1, spec = 1'b0, sbsel = 1'b0, cen = 1'b1;
  logic        clr_a = 1'b0, clr_g = 1'b0;
  logic [31:0] status;
  logic        irq;
  int checks = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  abort_cause_reg uut (
    .clk(clk), .rst_n(rst_n), .abort_evt_i(evt), .user_abort_i(usr),
    .flush_pulse_i(flush), .restart_en_i(rst_en), .special_en_i(spec),
    .start_byte_sel_i(sbsel), .ctrl_en_i(cen), .clr_abort_rd_i(clr_a),
    .clr_all_rd_i(clr_g), .status_o(status), .abort_irq_o(irq)
  );

  // {evt16, usr, clr_a, clr_g, restart/special/sbsel, expected bits 16:0}
  localparam int NV = 15;
  localparam logic [38:0] VEC [NV] = '{
    {16'h0001, 3'b000, 3'b100, 17'h00001},  // R2
    {16'h0008, 3'b000, 3'b100, 17'h00009},  // R2
    {16'h0000, 3'b001, 3'b100, 17'h00000},  // R5 global clear
    {16'h4000, 3'b000, 3'b100, 17'h05000},  // R3
    {16'h0000, 3'b100, 3'b100, 17'h15000},  // R4
    {16'h0000, 3'b010, 3'b100, 17'h00000},  // R5 abort clear
    {16'h0020, 3'b010, 3'b100, 17'h00020},  // R8
    {16'h0200, 3'b000, 3'b011, 17'h00220},  // R2 bit 9
    {16'h0000, 3'b010, 3'b011, 17'h00000},  // R6 drop
    {16'h0000, 3'b000, 3'b011, 17'h00200},  // R6 back
    {16'h0000, 3'b000, 3'b011, 17'h00200},  // R6 held
    {16'h0000, 3'b001, 3'b100, 17'h00000},  // R7 restart on
    {16'h0200, 3'b000, 3'b001, 17'h00200},  // R2
    {16'h0000, 3'b010, 3'b001, 17'h00000},  // R7 special off
    {16'h8000, 3'b011, 3'b100, 17'h08000}   // R8 both strobes
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    evt = '0; usr = 1'b0; clr_a = 1'b0; clr_g = 1'b0; flush = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 status", status, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {evt, usr, clr_a, clr_g, rst_en, spec, sbsel} = VEC[i][38:17];
      step();
      chk($sformatf("R2-table vec %0d status", i), status, {15'h0, VEC[i][16:0]});
      chk($sformatf("R9 vec %0d irq", i), {31'h0, irq}, {31'h0, VEC[i][16:0] != 17'h0});
    end
    @(negedge clk); idle(); rst_en = 1'b1; spec = 1'b0; sbsel = 1'b0;

    // R6: clearing with the fault present but bit 9 already 0 does not set it.
    @(negedge clk); rst_en = 1'b0; spec = 1'b1; sbsel = 1'b1; clr_a = 1'b1;
    step();
    @(negedge clk); clr_a = 1'b0;
    step();
    chk("R6 no rearm when bit 9 was clear", status, 32'h0);
    @(negedge clk); rst_en = 1'b1; spec = 1'b0; sbsel = 1'b0;

    // R10: three flush pulses.
    @(negedge clk); flush = 1'b1;
    repeat (3) step();
    @(negedge clk); flush = 1'b0;
    chk("R10 count three", status, {9'd3, 23'h0});
    // R10 / R12: read strobes leave the count alone.
    @(negedge clk); clr_a = 1'b1; clr_g = 1'b1;
    step();
    @(negedge clk); idle();
    chk("R12 strobes keep count", status, {9'd3, 23'h0});

    // R11: saturate.
    @(negedge clk); flush = 1'b1;
    repeat (520) step();
    chk("R11 saturated count", status, {9'd511, 23'h0});
    chk("R13 reserved zero", {26'h0, status[22:17]}, 32'h0);

    // R12: disable clears even with a flush pulse present.
    @(negedge clk); cen = 1'b0;
    step();
    chk("R12 disable clears count", status, 32'h0);
    @(negedge clk); cen = 1'b1; flush = 1'b0;
    step();
    chk("R12 count stays zero", status, 32'h0);

    report();
  end
endmodule